// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. After a start pulse it walks a binary trial code from the most significant bit downward, presents each trial to an external DAC, and reads a one-bit comparator verdict at the end of every step. A bit is kept when the comparator reports that the input is at or above the trial, and cleared otherwise. Each step lasts a fixed number of clock cycles. While the conversion runs, a busy flag is high and a conversion clock toggles once per step.

When the last bit is decided, the code is stored in a result register. It stays on the parallel outputs until the next conversion completes. Outputs use complementary coding: the parallel word and the serial line carry the inverse of each decision. A separate line carries the true MSB, so bipolar users can form complementary offset binary or complementary two's complement. A length selection can stop the sequence after 10 or 8 bits to shorten the conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: With `cmp_i` = 1 meaning "input ≥ trial", the stored result is the input truncated to the active bits, and `data_o` equals its bitwise inverse.
- R2: A conversion starts when `start_i` is sampled 1 on one rising edge and 0 on the next. `busy_o` goes to 1 on that second edge, and a new start restarts a conversion that is already running.
- R3: `short_sel_i` is sampled on the start edge. 2'b01 selects 10 bits, 2'b10 selects 8 bits, and 2'b00 or 2'b11 select 12 bits. `busy_o` stays 1 for exactly bits × `STEP_CYCLES` cycles, and changing `short_sel_i` during a conversion has no effect.
- R4: `data_o` keeps its value throughout a conversion and changes only on the edge that makes the final decision.
- R5: After each decision, `serial_o` shows the inverse of that decision, MSB first, and holds it until the next decision. It does not change while the block is idle.
- R6: In a short conversion, the bits that were never tried are 0 in the result, which shows as 1 on `data_o`.
- R7: `msb_true_o` equals the true (uninverted) MSB of the stored result, which is the inverse of `data_o[11]`.
- R8: During step k, `trial_o` holds the k−1 bits already decided, a 1 at the bit under trial, and zeros below it. The first trial is 12'h800.
- R9: `conv_clk_o` is high for the first `STEP_CYCLES`/2 cycles of each step and low whenever `busy_o` is 0.
- R10: A start during a conversion abandons it without touching `data_o`, and a conversion of full length follows.
- R11: If a start edge coincides with the final decision, that result is still stored and the new conversion begins with `busy_o` staying 1.
- R12: After reset, `busy_o`, `trial_o`, `msb_true_o` and `conv_clk_o` are 0, while `data_o` is all ones and `serial_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; its falling edge starts a conversion |
| short_sel_i | input | 2 | Conversion length select |
| cmp_i | input | 1 | Comparator verdict, 1 when input ≥ trial |
| trial_o | output | 12 | Trial code driven to the DAC |
| data_o | output | 12 | Stored result, complementary coding |
| msb_true_o | output | 1 | True MSB of the stored result |
| serial_o | output | 1 | Inverted decision stream, MSB first |
| busy_o | output | 1 | Conversion in progress |
| conv_clk_o | output | 1 | Conversion clock, one pulse per step |

## Verification
A start edge and the final bit decision can land on the same clock edge. When they do, the block must store the finished result and also begin a new conversion. The bench provokes this by timing the start pulse so that its falling edge is seen exactly on the last decision edge. It then checks that `busy_o` never drops, that `data_o` already shows the finished code, and that the next conversion runs its full length with a trial of 12'h800. The opposite case, a start edge in the middle of a step, is checked as well: `data_o` must stay unchanged across it.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        LEN_FULL   = 2'b00,
        LEN_SHORTA = 2'b01,
        LEN_SHORTB = 2'b10,
        LEN_FULL_X = 2'b11
    } len_sel_e;

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign fall_o = e_q.prev && !start_i;
endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
    parameter int unsigned STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic step_end_o,
    output logic phase_hi_o
);
    localparam int unsigned CW   = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
    localparam int unsigned HALF = STEP_CYCLES / 2;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
    localparam logic [CW-1:0] HI_N = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tim_st_t;

    tim_st_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear_i)                  t_d.cnt = '0;
        else if (run_i && t_q.cnt == LAST) t_d.cnt = '0;
        else if (run_i)               t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign step_end_o = run_i && (t_q.cnt == LAST);
    assign phase_hi_o = run_i && (t_q.cnt < HI_N);
endmodule

// File: rtl/sar_out_fmt.sv
module sar_out_fmt #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] result_i,
    input  logic         dec_i,
    output logic [W-1:0] data_o,
    output logic         msb_true_o,
    output logic         serial_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign data_o[i] = ~result_i[i];
    end
    assign msb_true_o = result_i[W-1];
    assign serial_o   = ~dec_i;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int unsigned W            = 12,
    parameter int unsigned STEP_CYCLES  = 4,
    parameter int unsigned SHORTA_BITS  = 10,
    parameter int unsigned SHORTB_BITS  = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   short_sel_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] data_o,
    output logic         msb_true_o,
    output logic         serial_o,
    output logic         busy_o,
    output logic         conv_clk_o
);
    import sar_pkg::*;

    localparam int unsigned IW = $clog2(W);
    localparam logic [IW-1:0] TOP_IDX  = IW'(W - 1);
    localparam logic [IW-1:0] STOP_A   = IW'(W - SHORTA_BITS);
    localparam logic [IW-1:0] STOP_B   = IW'(W - SHORTB_BITS);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [IW-1:0] stop;
        logic [W-1:0]  sar;
        logic [W-1:0]  result;
        logic          dec;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic          fall;
    logic          step_end;
    logic          phase_hi;
    logic          last_step;
    logic [W-1:0]  sar_dec;
    logic [IW-1:0] stop_sel;

    sar_start_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .fall_o  (fall)
    );

    sar_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (fall),
        .run_i      (s_q.busy),
        .step_end_o (step_end),
        .phase_hi_o (phase_hi)
    );

    always_comb begin
        case (len_sel_e'(short_sel_i))
            LEN_SHORTA: stop_sel = STOP_A;
            LEN_SHORTB: stop_sel = STOP_B;
            default:    stop_sel = '0;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        sar_dec   = s_q.sar;
        sar_dec[s_q.idx] = cmp_i;
        last_step = s_q.busy && step_end && (s_q.idx == s_q.stop);

        if (s_q.busy && step_end) s_d.dec = cmp_i;
        if (last_step)            s_d.result = sar_dec;

        if (fall) begin
            s_d.busy       = 1'b1;
            s_d.idx        = TOP_IDX;
            s_d.stop       = stop_sel;
            s_d.sar        = '0;
            s_d.sar[W-1]   = 1'b1;
        end else if (s_q.busy && step_end) begin
            s_d.sar = sar_dec;
            if (last_step) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.idx = IW'(s_q.idx - 1'b1);
                s_d.sar[IW'(s_q.idx - 1'b1)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sar_out_fmt #(.W(W)) u_fmt (
        .result_i   (s_q.result),
        .dec_i      (s_q.dec),
        .data_o     (data_o),
        .msb_true_o (msb_true_o),
        .serial_o   (serial_o)
    );

    assign trial_o    = s_q.sar;
    assign busy_o     = s_q.busy;
    assign conv_clk_o = phase_hi;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int unsigned W           = 12,
    parameter int unsigned STEP_CYCLES = 4,
    parameter int unsigned SHORTA_BITS = 10,
    parameter int unsigned SHORTB_BITS = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [1:0]   short_sel_i,
    input logic [W-1:0] data_o,
    input logic         serial_o,
    input logic         busy_o,
    input logic         conv_clk_o
);
    logic        prev_start;
    logic [15:0] len_cnt;
    logic [15:0] len_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_start <= 1'b0;
            len_cnt    <= '0;
            len_exp    <= '0;
        end else begin
            prev_start <= start_i;
            if (prev_start && !start_i) begin
                len_cnt <= '0;
                case (short_sel_i)
                    2'b01:   len_exp <= 16'(SHORTA_BITS * STEP_CYCLES);
                    2'b10:   len_exp <= 16'(SHORTB_BITS * STEP_CYCLES);
                    default: len_exp <= 16'(W * STEP_CYCLES);
                endcase
            end else if (busy_o && len_cnt != 16'hFFFF) begin
                len_cnt <= len_cnt + 1'b1;
            end
        end
    end

    // R2
    a_r2_busy_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_i) && !start_i) |=> busy_o);

    // R3
    a_r3_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (len_cnt == len_exp));

    // R4
    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> $past(busy_o));

    // R5
    a_r5_serial_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(serial_o) |-> $past(busy_o));

    // R9
    a_r9_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !conv_clk_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .W(W), .STEP_CYCLES(STEP_CYCLES),
    .SHORTA_BITS(SHORTA_BITS), .SHORTB_BITS(SHORTB_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_sel_i(short_sel_i),
    .data_o(data_o), .serial_o(serial_o), .busy_o(busy_o), .conv_clk_o(conv_clk_o)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
    localparam int W    = 12;
    localparam int STEP = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   short_sel_i = 2'b00;
    logic         cmp_i;
    logic [W-1:0] trial_o, data_o;
    logic         msb_true_o, serial_o, busy_o, conv_clk_o;

    int analog = 0;
    int last_exp = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign cmp_i = (analog >= int'(trial_o));

    sar_conv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_sel_i(short_sel_i),
        .cmp_i(cmp_i), .trial_o(trial_o), .data_o(data_o), .msb_true_o(msb_true_o),
        .serial_o(serial_o), .busy_o(busy_o), .conv_clk_o(conv_clk_o)
    );

    function automatic int bits_of(input logic [1:0] sel);
        if (sel == 2'b01) return 10;
        if (sel == 2'b10) return 8;
        return 12;
    endfunction

    function automatic int exp_code(input int a, input int n);
        return a & ~((1 << (W - n)) - 1) & 12'hFFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(posedge clk);
    endtask

    task automatic run_steps(input int a, input int n, input bit chain, input logic [1:0] nsel);
        int code;
        code = exp_code(a, n);
        @(negedge clk);
        analog = a;
        chk(busy_o == 1'b1, "R2 R11 busy after start", int'(busy_o), 1);
        chk(trial_o == 12'h800, "R8 first trial", int'(trial_o), 12'h800);
        chk(conv_clk_o == 1'b1, "R9 clock high in first half", int'(conv_clk_o), 1);
        chk(data_o == 12'(~last_exp), "R4 R10 data held at start", int'(data_o), int'(12'(~last_exp)));
        short_sel_i = 2'($urandom);
        for (int k = 1; k <= n; k++) begin
            int bitv;
            int hi;
            bitv = (code >> (W - k)) & 1;
            hi = code & ~((1 << (W - k)) - 1);
            if (chain && k == n) begin
                repeat (STEP - 2) @(posedge clk);
                @(negedge clk); start_i = 1'b1;
                @(negedge clk); start_i = 1'b0; short_sel_i = nsel;
                @(posedge clk);
                last_exp = code;
                return;
            end
            repeat (STEP) @(posedge clk);
            @(negedge clk);
            chk(serial_o == !bitv[0], "R5 serial decision", int'(serial_o), int'(!bitv[0]));
            if (k < n) begin
                chk(busy_o == 1'b1, "R3 busy mid", int'(busy_o), 1);
                chk(int'(trial_o) == (hi | (1 << (W - 1 - k))), "R8 trial", int'(trial_o),
                    hi | (1 << (W - 1 - k)));
                chk(data_o == 12'(~last_exp), "R4 data held", int'(data_o), int'(12'(~last_exp)));
            end else begin
                chk(busy_o == 1'b0, "R3 busy end", int'(busy_o), 0);
                chk(data_o == 12'(~code), "R1 result", int'(data_o), int'(12'(~code)));
                chk(msb_true_o == code[11], "R7 true msb", int'(msb_true_o), (code >> 11) & 1);
                chk(conv_clk_o == 1'b0, "R9 clock idle", int'(conv_clk_o), 0);
                if (n < W)
                    chk((data_o & 12'((1 << (W - n)) - 1)) == 12'((1 << (W - n)) - 1),
                        "R6 untried bits", int'(data_o), int'(12'(~code)));
            end
        end
        last_exp = code;
    endtask

    task automatic convert(input int a, input logic [1:0] sel);
        short_sel_i = sel;
        pulse_start();
        run_steps(a, bits_of(sel), 1'b0, 2'b00);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy_o == 1'b0, "R12 busy", int'(busy_o), 0);
        chk(data_o == 12'hFFF, "R12 data", int'(data_o), 12'hFFF);
        chk(serial_o == 1'b1, "R12 serial", int'(serial_o), 1);
        chk(trial_o == 12'h000, "R12 trial", int'(trial_o), 0);
        chk(conv_clk_o == 1'b0, "R12 conv clk", int'(conv_clk_o), 0);
        chk(msb_true_o == 1'b0, "R12 msb", int'(msb_true_o), 0);

        convert(0, 2'b00);
        convert(4095, 2'b00);
        convert(12'h800, 2'b11);
        convert(4095, 2'b10);
        convert(12'h7FF, 2'b01);
        convert(12'hA5C, 2'b10);

        // R10 restart mid-conversion
        short_sel_i = 2'b10;
        pulse_start();
        @(negedge clk); analog = 12'h3F0;
        repeat (10) @(posedge clk);
        short_sel_i = 2'b00;
        pulse_start();
        run_steps(12'h9C3, 12, 1'b0, 2'b00);

        // R11 start edge on final decision
        short_sel_i = 2'b01;
        pulse_start();
        run_steps(12'h5A5, 10, 1'b1, 2'b10);
        run_steps(12'h3C3, 8, 1'b0, 2'b00);

        for (int i = 0; i < 40; i++) begin
            convert(int'($urandom_range(0, 4095)), 2'($urandom));
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
        end

        @(negedge clk);
        chk(serial_o == serial_o && busy_o == 1'b0, "R5 idle", int'(busy_o), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule